// File: doc/BRIEF.md
# Thermal Throttle and Temperature Monitor

This block receives composite temperature readings in degrees Celsius from a sensor front end. Each reading arrives with a one-cycle valid strobe. From these readings it decides when the write path must be slowed, and it drives a single throttle level to that path. The throttle engages above a fixed trip point and releases only after the temperature has dropped 2 °C below that trip point. This hysteresis stops the throttle from toggling on sensor noise.

Next to the throttle decision, the block keeps a log for health reporting. It holds the current, highest and lowest readings since reset in Kelvin. It counts whole minutes spent throttling, using a clock prescaler as its timebase, and that count stops at all-ones. It raises a critical-warning level whenever the last reading exceeds a threshold that the host programs. It also offers the last Celsius reading one byte at a time, low byte first, to a sideband register reader.

The design is built around two small state machines. `tg_throttle_fsm` has the states COOL and HOT. The transition ENGAGE goes from COOL to HOT on a valid reading above 75 °C. The transition RELEASE goes from HOT to COOL on a valid reading of 73 °C or below. In every other case the state holds. `tg_temp_log` has the states EMPTY and TRACK. The transition FIRST goes from EMPTY to TRACK on the first valid reading, and TRACK holds until reset. `tg_timebase` supplies a one-cycle minute pulse.

Top module: `thermal_guard`

## Requirements
- R1: After reset, throttle_on, crit_warn, throttle_minutes, temp_cur_k, temp_max_k, temp_min_k and rd_byte are all 0.
- R2: A valid reading strictly above 75 °C sets throttle_on from the next cycle. A reading of exactly 75 °C or 74 °C while not throttling leaves it at 0.
- R3: While throttling, readings of 74 °C or higher keep throttle_on at 1. A valid reading of 73 °C or below clears it from the next cycle.
- R4: While samp_valid is 0, samp_celsius has no effect on throttle_on or on any logged temperature.
- R5: A minute pulse occurs once every MINUTE_CYCLES clock cycles, counted from reset release. throttle_minutes increases by one on a pulse only when throttle_on is 1.
- R6: throttle_minutes saturates at all-ones and stays there while throttling continues.
- R7: One cycle after a valid reading, temp_cur_k equals that reading in Celsius plus 273.
- R8: The first valid reading after reset loads temp_max_k and temp_min_k with its Kelvin value.
- R9: After the first reading, temp_max_k changes only for a strictly higher value and temp_min_k only for a strictly lower value.
- R10: crit_warn is 1 exactly when a reading has been logged and the last reading, as a signed value, is strictly greater than crit_limit_c. A change of crit_limit_c takes effect in the same cycle.
- R11: rd_byte returns the low byte of the last 16-bit two's-complement Celsius reading when rd_hi is 0, and the high byte when rd_hi is 1. For example, 41 °C reads as 0x29 then 0x00, and -5 °C reads as 0xFB then 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_valid | input | 1 | One-cycle strobe marking a new reading |
| samp_celsius | input | 16 | Signed reading in degrees Celsius |
| crit_limit_c | input | 16 | Signed critical threshold in degrees Celsius, set by the host |
| rd_hi | input | 1 | Byte select for the sideband read: 0 selects the low byte, 1 the high byte |
| throttle_on | output | 1 | Write throttle request and status flag |
| crit_warn | output | 1 | Critical temperature warning |
| throttle_minutes | output | MINUTE_W | Saturating count of minutes spent throttling |
| temp_cur_k | output | 16 | Last reading in Kelvin |
| temp_max_k | output | 16 | Highest reading since reset in Kelvin |
| temp_min_k | output | 16 | Lowest reading since reset in Kelvin |
| rd_byte | output | 8 | Selected byte of the last Celsius reading |

## Verification
The states that are hardest to reach from the ports are a saturated minute counter and a partly elapsed minute at the moment the throttle changes. With the default sizes these would need real minutes and billions of throttled minutes. The bench therefore builds the block with a 16-cycle minute and a 3-bit counter. It runs a cycle-accurate reference of the prescaler and the hysteresis beside the block, derived only from the requirements. The throttle is then held across many pulses, both to drive the counter into saturation and to compare it against the reference after every change of throttle state.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
    localparam int TEMP_W        = 16;
    localparam int KELVIN_OFFSET = 273;

    typedef logic signed [TEMP_W-1:0] celsius_t;
    typedef logic        [TEMP_W-1:0] kelvin_t;

    typedef enum logic {
        TH_COOL = 1'b0,
        TH_HOT  = 1'b1
    } throttle_state_e;

    typedef enum logic {
        LG_EMPTY = 1'b0,
        LG_TRACK = 1'b1
    } log_state_e;
endpackage

// File: rtl/tg_timebase.sv
module tg_timebase #(
    parameter int unsigned MINUTE_CYCLES = 60_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (MINUTE_CYCLES > 1) ? $clog2(MINUTE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(MINUTE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

    // R5: the prescaler never runs past its last count
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    generate
        if (MINUTE_CYCLES > 1) begin : g_spacing
            // R5: two minute pulses are never adjacent
            assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tg_throttle_fsm.sv
module tg_throttle_fsm
    import thermal_pkg::*;
#(
    parameter int TRIP_C    = 75,
    parameter int RELEASE_C = 73
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     valid,
    input  celsius_t celsius,
    output logic     active
);
    localparam celsius_t TRIP_S    = celsius_t'(TRIP_C);
    localparam celsius_t RELEASE_S = celsius_t'(RELEASE_C);

    throttle_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TH_COOL;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: ENGAGE and RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_COOL: if (valid && (celsius > TRIP_S))     state_d = TH_HOT;
            TH_HOT:  if (valid && (celsius <= RELEASE_S)) state_d = TH_COOL;
            default: state_d = TH_COOL;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            TH_HOT:  active = 1'b1;
            default: active = 1'b0;
        endcase
    end

    assert_engage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (celsius > TRIP_S)) |=> active);

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (celsius <= RELEASE_S)) |=> !active);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(active));
endmodule

// File: rtl/tg_temp_log.sv
module tg_temp_log
    import thermal_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     valid,
    input  celsius_t celsius,
    output logic     have_sample,
    output celsius_t cur_c,
    output kelvin_t  cur_k,
    output kelvin_t  max_k,
    output kelvin_t  min_k
);
    log_state_e state_q, state_d;
    kelvin_t    new_k;

    assign new_k = kelvin_t'(celsius + celsius_t'(KELVIN_OFFSET));

    // next state: FIRST
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LG_EMPTY: if (valid) state_d = LG_TRACK;
            LG_TRACK: state_d = LG_TRACK;
            default:  state_d = LG_EMPTY;
        endcase
    end

    // state and log registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LG_EMPTY;
            cur_c   <= '0;
            cur_k   <= '0;
            max_k   <= '0;
            min_k   <= '0;
        end else begin
            state_q <= state_d;
            if (valid) begin
                cur_c <= celsius;
                cur_k <= new_k;
                unique case (state_q)
                    LG_EMPTY: begin
                        max_k <= new_k;
                        min_k <= new_k;
                    end
                    LG_TRACK: begin
                        if (new_k > max_k) max_k <= new_k;
                        if (new_k < min_k) min_k <= new_k;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LG_TRACK: have_sample = 1'b1;
            default:  have_sample = 1'b0;
        endcase
    end

    assert_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        have_sample |-> (min_k <= max_k));

    assert_max_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (have_sample && $past(have_sample)) |-> (max_k >= $past(max_k)));

    assert_min_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (have_sample && $past(have_sample)) |-> (min_k <= $past(min_k)));

    assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(cur_k));
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_pkg::*;
#(
    parameter int unsigned MINUTE_CYCLES = 60_000_000,
    parameter int          MINUTE_W      = 32,
    parameter int          TRIP_C        = 75,
    parameter int          RELEASE_C     = 73
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       samp_valid,
    input  logic signed [TEMP_W-1:0]   samp_celsius,
    input  logic signed [TEMP_W-1:0]   crit_limit_c,
    input  logic                       rd_hi,
    output logic                       throttle_on,
    output logic                       crit_warn,
    output logic [MINUTE_W-1:0]        throttle_minutes,
    output logic [TEMP_W-1:0]          temp_cur_k,
    output logic [TEMP_W-1:0]          temp_max_k,
    output logic [TEMP_W-1:0]          temp_min_k,
    output logic [7:0]                 rd_byte
);
    localparam logic [MINUTE_W-1:0] MIN_FULL = '1;

    logic     minute_tick;
    logic     have_sample;
    celsius_t last_c;

    tg_timebase #(
        .MINUTE_CYCLES(MINUTE_CYCLES)
    ) u_timebase (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (minute_tick)
    );

    tg_throttle_fsm #(
        .TRIP_C   (TRIP_C),
        .RELEASE_C(RELEASE_C)
    ) u_throttle (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (samp_valid),
        .celsius(samp_celsius),
        .active (throttle_on)
    );

    tg_temp_log u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (samp_valid),
        .celsius    (samp_celsius),
        .have_sample(have_sample),
        .cur_c      (last_c),
        .cur_k      (temp_cur_k),
        .max_k      (temp_max_k),
        .min_k      (temp_min_k)
    );

    // saturating throttle-minute accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            throttle_minutes <= '0;
        end else if (minute_tick && throttle_on && (throttle_minutes != MIN_FULL)) begin
            throttle_minutes <= throttle_minutes + 1'b1;
        end
    end

    assign crit_warn = have_sample && (last_c > crit_limit_c);
    assign rd_byte   = rd_hi ? last_c[15:8] : last_c[7:0];

    assert_minutes_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !throttle_on |=> $stable(throttle_minutes));

    assert_minutes_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle_minutes != $past(throttle_minutes)) |->
            (throttle_minutes == $past(throttle_minutes) + 1'b1));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle_minutes == MIN_FULL) |=> (throttle_minutes == MIN_FULL));

    assert_crit_needs_log_R10: assert property (@(posedge clk) disable iff (!rst_n)
        crit_warn |-> have_sample);
endmodule

// File: tb/tb_thermal_guard.sv
`timescale 1ns/1ps
module tb_thermal_guard;
    localparam int N  = 16;
    localparam int MW = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               samp_valid = 1'b0;
    logic signed [15:0] samp_celsius = '0;
    logic signed [15:0] crit_limit_c = '0;
    logic               rd_hi = 1'b0;
    logic               throttle_on;
    logic               crit_warn;
    logic [MW-1:0]      throttle_minutes;
    logic [15:0]        temp_cur_k;
    logic [15:0]        temp_max_k;
    logic [15:0]        temp_min_k;
    logic [7:0]         rd_byte;

    thermal_guard #(
        .MINUTE_CYCLES(N),
        .MINUTE_W     (MW)
    ) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .samp_valid      (samp_valid),
        .samp_celsius    (samp_celsius),
        .crit_limit_c    (crit_limit_c),
        .rd_hi           (rd_hi),
        .throttle_on     (throttle_on),
        .crit_warn       (crit_warn),
        .throttle_minutes(throttle_minutes),
        .temp_cur_k      (temp_cur_k),
        .temp_max_k      (temp_max_k),
        .temp_min_k      (temp_min_k),
        .rd_byte         (rd_byte)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // reference model of prescaler, hysteresis and minute count (R5, R6)
    int m_cnt;
    bit m_hot;
    int m_min;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0;
            m_hot <= 1'b0;
            m_min <= 0;
        end else begin
            if (m_cnt == N - 1 && m_hot && m_min != (1 << MW) - 1) m_min <= m_min + 1;
            m_cnt <= (m_cnt == N - 1) ? 0 : m_cnt + 1;
            if (samp_valid && samp_celsius > 75)       m_hot <= 1'b1;
            else if (samp_valid && samp_celsius <= 73) m_hot <= 1'b0;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample(input int c);
        @(negedge clk);
        samp_valid   = 1'b1;
        samp_celsius = 16'(c);
        @(negedge clk);
        samp_valid   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        crit_limit_c = -16'sd100;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 throttle", throttle_on, 0);
        chk("R1 minutes", throttle_minutes, 0);
        chk("R1 cur_k", temp_cur_k, 0);
        chk("R1 max_k", temp_max_k, 0);
        chk("R1 min_k", temp_min_k, 0);
        chk("R10 no warn before first reading", crit_warn, 0);
        chk("R1 rd_byte", rd_byte, 0);
    endtask

    task automatic t_minmax;
        crit_limit_c = 16'sd100;
        sample(30);
        chk("R7 cur after 30", temp_cur_k, 303);
        chk("R8 first max", temp_max_k, 303);
        chk("R8 first min", temp_min_k, 303);
        sample(50);
        chk("R9 max up", temp_max_k, 323);
        chk("R9 min kept", temp_min_k, 303);
        sample(20);
        chk("R9 min down", temp_min_k, 293);
        chk("R9 max kept", temp_max_k, 323);
        sample(50);
        chk("R9 equal max", temp_max_k, 323);
        chk("R7 cur 50", temp_cur_k, 323);
        sample(-5);
        chk("R7 cur negative", temp_cur_k, 268);
        chk("R9 min negative", temp_min_k, 268);
    endtask

    task automatic t_readback;
        sample(41);
        rd_hi = 1'b0; #1;
        chk("R11 41 low", rd_byte, 8'h29);
        rd_hi = 1'b1; #1;
        chk("R11 41 high", rd_byte, 8'h00);
        sample(-5);
        rd_hi = 1'b0; #1;
        chk("R11 -5 low", rd_byte, 8'hFB);
        rd_hi = 1'b1; #1;
        chk("R11 -5 high", rd_byte, 8'hFF);
        rd_hi = 1'b0;
    endtask

    task automatic t_engage;
        sample(75);
        chk("R2 at 75", throttle_on, 0);
        sample(74);
        chk("R2 74 cool", throttle_on, 0);
        sample(76);
        chk("R2 at 76", throttle_on, 1);
    endtask

    task automatic t_hyst;
        sample(74);
        chk("R3 hold 74", throttle_on, 1);
        sample(80);
        chk("R3 hold 80", throttle_on, 1);
        sample(73);
        chk("R3 release 73", throttle_on, 0);
        chk("R5 minutes", throttle_minutes, m_min);
    endtask

    task automatic t_ignore;
        @(negedge clk);
        samp_celsius = 16'sd100;
        idle(5);
        chk("R4 cool ignores", throttle_on, 0);
        chk("R4 cur kept", temp_cur_k, 346);
        sample(90);
        chk("R2 at 90", throttle_on, 1);
        samp_celsius = 16'sd0;
        idle(5);
        chk("R4 hot ignores", throttle_on, 1);
        chk("R4 min kept", temp_min_k, 268);
        chk("R4 cur kept hot", temp_cur_k, 363);
        sample(20);
        chk("R3 release 20", throttle_on, 0);
    endtask

    task automatic t_crit;
        crit_limit_c = 16'sd60;
        sample(61);
        chk("R10 above", crit_warn, 1);
        sample(60);
        chk("R10 equal", crit_warn, 0);
        crit_limit_c = 16'sd59; #1;
        chk("R10 limit lowered", crit_warn, 1);
        crit_limit_c = 16'sd100; #1;
        chk("R10 limit raised", crit_warn, 0);
    endtask

    task automatic t_minutes;
        sample(80);
        idle(3 * N + 5);
        chk("R5 minutes hot", throttle_minutes, m_min);
        sample(50);
        idle(2 * N);
        chk("R5 minutes cool", throttle_minutes, m_min);
    endtask

    task automatic t_sat;
        sample(90);
        idle(((1 << MW) + 2) * N);
        chk("R6 saturated", throttle_minutes, (1 << MW) - 1);
        idle(N + 1);
        chk("R6 stays", throttle_minutes, (1 << MW) - 1);
        chk("R5 model", throttle_minutes, m_min);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_minmax();
        t_readback();
        t_engage();
        t_hyst();
        t_ignore();
        t_crit();
        t_minutes();
        t_sat();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule